// File: doc/BRIEF.md
# Selectable Square-Wave Output with Alarm Sharing

This block turns a 32768 Hz timebase into one of fifteen fixed square-wave frequencies, ranging from 32768 Hz down to 1/32 Hz. A 4-bit code picks the frequency. The result drives a single open-drain, active-low pin that also carries the alarm interrupt. The block's only output is a pull-low enable. The pad cell turns that enable into the pin.

The timebase arrives as a one-cycle enable, `tb_tick`, that pulses on every edge of the 32768 Hz clock, so it pulses 65536 times per second. A 21-bit binary divider counts these pulses and never stops. Each frequency is one bit of that divider, so every output has an exact 50% duty cycle.

A nonzero code puts the pin in frequency mode, and the alarm request is then ignored. Code zero hands the pin to the alarm request. A separate control bit can release the pin completely while the system runs from its backup supply.

Top module: `fout_pin_mux`

## Requirements
- R1: After reset the divider count is zero, the latched code is zero and the pin is released (`pin_pull_low` = 0) while `alarm_irq` is low.
- R2: Let T be the number of `tb_tick` pulses since reset, and let k be the divider bit for the latched code. The codes map to divider bits and frequencies as follows: 1→0 (32768 Hz), 2→3 (4096 Hz), 3→5 (1024 Hz), 4→9 (64 Hz), 5→10, 6→11, 7→12, 8→13, 9→14, 10→15 (1 Hz), 11→16, 12→17, 13→18, 14→19, 15→20 (1/32 Hz). In frequency mode the pin is pulled low exactly when bit k of T is 0.
- R3: With code 1 the pin level inverts on every `tb_tick`, so the output follows the timebase directly.
- R4: In frequency mode each level lasts exactly 2^k ticks, which gives a 50% duty cycle.
- R5: With latched code 0 and no blanking, `pin_pull_low` equals `alarm_irq` in the same cycle.
- R6: With a nonzero latched code, `alarm_irq` has no effect on the pin.
- R7: When `on_battery` and `blank_on_battery` are both 1, the pin is released whatever the code and the alarm request are.
- R8: If only one of `on_battery` and `blank_on_battery` is 1, the pin behaves normally.
- R9: A new `freq_sel` value is latched only on a cycle with `tb_tick` high. Between ticks the pin keeps following the old code.
- R10: The divider counts every tick whatever the code. After a change of code the new output is already in phase with T, with no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_tick | input | 1 | One-cycle enable on each edge of the 32768 Hz timebase |
| freq_sel | input | 4 | Frequency code, 0 = alarm mode |
| on_battery | input | 1 | System is running from the backup supply |
| blank_on_battery | input | 1 | Release the pin while on the backup supply |
| alarm_irq | input | 1 | Alarm interrupt request, active high |
| pin_pull_low | output | 1 | 1 = drive the shared pin low, 0 = release it |

## Verification
The embedded assertions check four things on every cycle:
- the divider advances by exactly one on each tick and holds otherwise;
- the latched code and wave level stay frozen between ticks;
- the code-1 output inverts on each tick;
- the pin is always released when blanked on battery.

Only the bench's scenarios can show the other behaviours. These are the mapping from each code to its divider bit, the exact half-period lengths, and the fact that the alarm is ignored in frequency mode. They also include the phase continuity after a code change. The bench shows these by comparing the pin, tick by tick, with a tick count it keeps itself.

// File: rtl/fout_pin_mux.sv
module fout_pin_mux #(
  parameter int DIV_W = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_tick,
  input  logic [3:0] freq_sel,
  input  logic       on_battery,
  input  logic       blank_on_battery,
  input  logic       alarm_irq,
  output logic       pin_pull_low
);

  localparam int IDX_W = $clog2(DIV_W);

  function automatic logic [IDX_W-1:0] tap_of(input logic [3:0] code);
    case (code)
      4'd1:    tap_of = IDX_W'(0);
      4'd2:    tap_of = IDX_W'(3);
      4'd3:    tap_of = IDX_W'(5);
      default: tap_of = IDX_W'(int'(code) + 5);
    endcase
  endfunction

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nx;
  logic [3:0]       code_q;
  logic             wave_q;
  logic             blank;

  assign div_nx = div_q + 1'b1;
  assign blank  = on_battery & blank_on_battery;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      code_q <= 4'd0;
      wave_q <= 1'b0;
    end else if (tb_tick) begin
      div_q  <= div_nx;
      code_q <= freq_sel;
      wave_q <= (freq_sel == 4'd0) ? 1'b1 : div_nx[tap_of(freq_sel)];
    end
  end

  assign pin_pull_low = blank ? 1'b0 : ((code_q == 4'd0) ? alarm_irq : ~wave_q);

  assert_div_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tb_tick |=> div_q == $past(div_q) + 1'b1);

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_tick |=> ($stable(code_q) && $stable(wave_q) && $stable(div_q)));

  assert_fast_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && freq_sel == 4'd1 && code_q == 4'd1) |=> wave_q != $past(wave_q));

  assert_blank_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && blank_on_battery) |-> !pin_pull_low);

endmodule

// File: tb/fout_pin_mux_test.sv
module fout_pin_mux_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_tick = 1'b0;
  logic [3:0] freq_sel = 4'd0;
  logic       on_battery = 1'b0;
  logic       blank_on_battery = 1'b0;
  logic       alarm_irq = 1'b0;
  logic       pin_pull_low;

  int checks = 0;
  int errors = 0;
  int tcount = 0;
  int cycles = 0;
  logic [3:0] code_seen = 4'd0;
  bit finished = 0;

  always #4 clk = ~clk;

  fout_pin_mux uut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .freq_sel(freq_sel),
    .on_battery(on_battery), .blank_on_battery(blank_on_battery),
    .alarm_irq(alarm_irq), .pin_pull_low(pin_pull_low)
  );

  function automatic int tap(input logic [3:0] c);
    case (c)
      4'd1: return 0;
      4'd2: return 3;
      4'd3: return 5;
      default: return int'(c) + 5;
    endcase
  endfunction

  function automatic logic model_pin();
    if (on_battery && blank_on_battery) return 1'b0;
    if (code_seen == 4'd0) return alarm_irq;
    return ~tcount[tap(code_seen)];
  endfunction

  task automatic expect_pin(input string req);
    logic e;
    e = model_pin();
    checks++;
    if (pin_pull_low !== e) begin
      errors++;
      $display("FAIL %s: T=%0d code=%0d pin=%b expected=%b", req, tcount, code_seen, pin_pull_low, e);
    end
  endtask

  task automatic run_ticks(input int n, input string req);
    tb_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tcount++;
      code_seen = freq_sel;
      expect_pin(req);
    end
    tb_tick = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    tb_tick = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expect_pin(req);
    end
  endtask

  task automatic test_reset();
    idle(2, "R1");
    alarm_irq = 1'b1;
    #1 expect_pin("R5");
    alarm_irq = 1'b0;
    #1 expect_pin("R5");
  endtask

  task automatic test_follow();
    freq_sel = 4'd1;
    run_ticks(16, "R3");
  endtask

  task automatic test_fast_codes();
    for (int c = 2; c <= 8; c++) begin
      freq_sel = 4'(c);
      run_ticks(2 << tap(4'(c)), "R2 R4");
    end
  endtask

  task automatic test_slow_codes();
    for (int c = 9; c <= 15; c++) begin
      freq_sel = 4'(c);
      run_ticks(4096, "R2");
    end
    freq_sel = 4'd11;
    while (tcount < 66000) run_ticks(1000, "R4");
  endtask

  task automatic test_alarm_ignored();
    freq_sel = 4'd4;
    run_ticks(3, "R6");
    alarm_irq = 1'b1;
    run_ticks(1500, "R6");
    idle(3, "R6");
    alarm_irq = 1'b0;
    idle(2, "R6");
  endtask

  task automatic test_blank();
    freq_sel = 4'd1;
    on_battery = 1'b1;
    blank_on_battery = 1'b1;
    run_ticks(6, "R7");
    freq_sel = 4'd0;
    alarm_irq = 1'b1;
    run_ticks(2, "R7");
    blank_on_battery = 1'b0;
    idle(2, "R8");
    on_battery = 1'b0;
    blank_on_battery = 1'b1;
    idle(2, "R8");
    alarm_irq = 1'b0;
    blank_on_battery = 1'b0;
    idle(1, "R8");
  endtask

  task automatic test_switch();
    freq_sel = 4'd1;
    run_ticks(3, "R10");
    freq_sel = 4'd4;
    idle(4, "R9");
    run_ticks(1, "R10");
    freq_sel = 4'd0;
    alarm_irq = 1'b1;
    idle(3, "R9");
    run_ticks(1, "R5");
    alarm_irq = 1'b0;
    idle(1, "R5");
    freq_sel = 4'd2;
    run_ticks(40, "R10");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_follow();
    test_fast_codes();
    test_alarm_ignored();
    test_blank();
    test_switch();
    test_slow_codes();
    finish_run();
  end
endmodule